// File: doc/BRIEF.md
# Speculative-Wakeup Issue Queue

This block sits between rename and the execution units of an out-of-order core. Each cycle it can accept one renamed instruction, which carries a destination tag, two source tags with their ready flags, a latency class (single-cycle ALU or load) and a program-order age. The queue holds each instruction until both sources are known to arrive in time. It then picks up to four ready instructions per cycle, oldest first, and sends them to the functional units.

Wakeup is speculative and is timed by the producer's latency. Dependents do not wait for a result to be written back. When an ALU-class instruction issues, its destination tag is broadcast in the same cycle, so a dependent can issue in the next cycle. A load-class instruction broadcasts its tag one cycle later, which leaves a single bubble. The `full` output tells decode to stall. A mispredict flush discards every entry younger than the branch's age.

Top module: `spec_wakeup_iq`

## Requirements
- R1: While reset is asserted and after it is released with nothing inserted, all `iss_valid` bits and `full` are 0.
- R2: An instruction presented with `in_valid` while `full` is 1 is dropped and never issues.
- R3: `full` is 1 exactly when all DEPTH entries hold an instruction.
- R4: An entry issues only when both of its sources are ready. An instruction inserted with both ready flags set can issue in the cycle after insertion, and no earlier.
- R5: At most ISSUE_W entries issue per cycle. The ready entries with the lowest ages are chosen. Slot 0 carries the oldest, the slots fill from 0 upward with no gaps, and slot k's destination is `iss_dst[k*TAG_W +: TAG_W]`.
- R6: If an ALU-class producer (`in_is_load`=0) issues in cycle t, a dependent already in the queue can issue in cycle t+1.
- R7: If a load-class producer (`in_is_load`=1) issues in cycle t, its dependents cannot issue before cycle t+2, and can issue in cycle t+2.
- R8: A tag that is broadcast in the same cycle as an insertion sets the matching source ready bit of the incoming instruction.
- R9: In a cycle with `flush_valid`, entries with age greater than `flush_age` do not issue and are removed. An insertion whose age is greater than `flush_age` is dropped. Older entries are unaffected.
- R10: An issued entry leaves the queue at the end of its issue cycle and issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Insert request |
| in_age | input | AGE_W | Program-order age of the incoming instruction (larger is younger) |
| in_dst | input | TAG_W | Destination physical tag |
| in_src1 | input | TAG_W | First source tag |
| in_src1_rdy | input | 1 | First source already available |
| in_src2 | input | TAG_W | Second source tag |
| in_src2_rdy | input | 1 | Second source already available |
| in_is_load | input | 1 | Latency class: 1 = load, 0 = ALU |
| flush_valid | input | 1 | Mispredict flush |
| flush_age | input | AGE_W | Age of the mispredicted branch |
| full | output | 1 | No free entry; decode must stall |
| iss_valid | output | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_dst | output | ISSUE_W*TAG_W | Destination tag per issue slot |
| iss_is_load | output | ISSUE_W | Latency class per issue slot |

## Verification
A fan-out pattern parks six consumers behind one ALU producer that is inserted last. This separates oldest-first selection and the four-slot cap from plain arrival order, and it shows the one-cycle ALU wakeup. Load-then-consumer pairs separate the two wakeup latencies, and a consumer inserted in the very cycle of the delayed broadcast exercises the bypass into the insertion path. A fill-to-full run with extra inserts, partial flushes of stuck and of ready entries, and a long random mix with periodic flushes are each compared cycle by cycle against a behavioural model of the queue.

// File: rtl/swiq_pkg.sv
package swiq_pkg;
  typedef enum logic {
    LAT_ALU  = 1'b0,
    LAT_LOAD = 1'b1
  } lat_e;
endpackage

// File: rtl/swiq_select.sv
module swiq_select #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  parameter int AGE_W   = 8,
  localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
  input  logic [DEPTH-1:0]        cand,
  input  logic [DEPTH*AGE_W-1:0]  age_flat,
  output logic [DEPTH-1:0]        sel,
  output logic [DEPTH*SLOT_W-1:0] slot_flat
);
  // number of ready candidates strictly older than entry i
  function automatic int older_ready(input int i, input logic [DEPTH-1:0] c,
                                     input logic [DEPTH*AGE_W-1:0] ages);
    int n;
    n = 0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j != i && c[j] && (ages[j*AGE_W +: AGE_W] < ages[i*AGE_W +: AGE_W])) n++;
    end
    return n;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_rank
    int rank;
    always_comb begin
      rank = older_ready(g, cand, age_flat);
      sel[g] = cand[g] && (rank < ISSUE_W);
      slot_flat[g*SLOT_W +: SLOT_W] = SLOT_W'(rank);
    end
  end
endmodule

// File: rtl/swiq_bcast.sv
module swiq_bcast
  import swiq_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int TAG_W   = 6,
  localparam int BC_N   = 2 * ISSUE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ISSUE_W-1:0]       iss_valid,
  input  logic [ISSUE_W-1:0]       iss_is_load,
  input  logic [ISSUE_W*TAG_W-1:0] iss_dst,
  output logic [BC_N-1:0]          bc_vld,
  output logic [BC_N*TAG_W-1:0]    bc_tag,
  output logic [ISSUE_W-1:0]       load_bc_vld
);
  logic [ISSUE_W-1:0]       ld_pend_q;
  logic [ISSUE_W*TAG_W-1:0] ld_tag_q;
  logic [ISSUE_W-1:0]       alu_now;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_cls
    assign alu_now[k] = iss_valid[k] && (lat_e'(iss_is_load[k]) == LAT_ALU);
  end

  // load producers broadcast one cycle after issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend_q <= '0;
      ld_tag_q  <= '0;
    end else begin
      ld_pend_q <= iss_valid & ~alu_now;
      ld_tag_q  <= iss_dst;
    end
  end

  assign bc_vld      = {ld_pend_q, alu_now};
  assign bc_tag      = {ld_tag_q, iss_dst};
  assign load_bc_vld = ld_pend_q;
endmodule

// File: rtl/spec_wakeup_iq.sv
module spec_wakeup_iq #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  parameter int TAG_W   = 6,
  parameter int AGE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [AGE_W-1:0]         in_age,
  input  logic [TAG_W-1:0]         in_dst,
  input  logic [TAG_W-1:0]         in_src1,
  input  logic                     in_src1_rdy,
  input  logic [TAG_W-1:0]         in_src2,
  input  logic                     in_src2_rdy,
  input  logic                     in_is_load,
  input  logic                     flush_valid,
  input  logic [AGE_W-1:0]         flush_age,
  output logic                     full,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*TAG_W-1:0] iss_dst,
  output logic [ISSUE_W-1:0]       iss_is_load
);
  localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;
  localparam int BC_N   = 2 * ISSUE_W;

  logic [DEPTH-1:0]        vld_q, r1_q, r2_q, ld_q;
  logic [TAG_W-1:0]        s1_q [DEPTH];
  logic [TAG_W-1:0]        s2_q [DEPTH];
  logic [TAG_W-1:0]        dst_q[DEPTH];
  logic [AGE_W-1:0]        age_q[DEPTH];
  logic [DEPTH*AGE_W-1:0]  age_flat;
  logic [DEPTH-1:0]        kill, cand, sel, free_oh;
  logic [DEPTH*SLOT_W-1:0] slot_flat;
  logic [BC_N-1:0]         bc_vld;
  logic [BC_N*TAG_W-1:0]   bc_tag;
  logic [ISSUE_W-1:0]      load_bc_vld;
  logic                    accept, in_r1, in_r2;

  function automatic logic tag_woken(input logic [TAG_W-1:0] t,
                                     input logic [BC_N-1:0] v,
                                     input logic [BC_N*TAG_W-1:0] tags);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < BC_N; k++) begin
      if (v[k] && (tags[k*TAG_W +: TAG_W] == t)) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic is_younger(input logic [AGE_W-1:0] a,
                                      input logic [AGE_W-1:0] lim);
    return a > lim;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      kill[i] = vld_q[i] && flush_valid && is_younger(age_q[i], flush_age);
      cand[i] = vld_q[i] && r1_q[i] && r2_q[i] && !kill[i];
      age_flat[i*AGE_W +: AGE_W] = age_q[i];
    end
  end

  swiq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .AGE_W(AGE_W)) u_sel (
    .cand(cand), .age_flat(age_flat), .sel(sel), .slot_flat(slot_flat)
  );

  // route each selected entry to its slot
  always_comb begin
    iss_valid   = '0;
    iss_dst     = '0;
    iss_is_load = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < ISSUE_W; s++) begin
        if (sel[i] && (slot_flat[i*SLOT_W +: SLOT_W] == SLOT_W'(s))) begin
          iss_valid[s]                = 1'b1;
          iss_dst[s*TAG_W +: TAG_W]   = dst_q[i];
          iss_is_load[s]              = ld_q[i];
        end
      end
    end
  end

  swiq_bcast #(.ISSUE_W(ISSUE_W), .TAG_W(TAG_W)) u_bc (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_is_load(iss_is_load),
    .iss_dst(iss_dst), .bc_vld(bc_vld), .bc_tag(bc_tag), .load_bc_vld(load_bc_vld)
  );

  // lowest free entry
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign full   = &vld_q;
  assign accept = in_valid && !full && !(flush_valid && is_younger(in_age, flush_age));
  assign in_r1  = in_src1_rdy || tag_woken(in_src1, bc_vld, bc_tag);
  assign in_r2  = in_src2_rdy || tag_woken(in_src2, bc_vld, bc_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      r1_q  <= '0;
      r2_q  <= '0;
      ld_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        s1_q[i]  <= '0;
        s2_q[i]  <= '0;
        dst_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld_q[i]) begin
          if (sel[i] || kill[i]) begin
            vld_q[i] <= 1'b0;
          end else begin
            if (tag_woken(s1_q[i], bc_vld, bc_tag)) r1_q[i] <= 1'b1;
            if (tag_woken(s2_q[i], bc_vld, bc_tag)) r2_q[i] <= 1'b1;
          end
        end else if (accept && free_oh[i]) begin
          vld_q[i] <= 1'b1;
          r1_q[i]  <= in_r1;
          r2_q[i]  <= in_r2;
          ld_q[i]  <= in_is_load;
          s1_q[i]  <= in_src1;
          s2_q[i]  <= in_src2;
          dst_q[i] <= in_dst;
          age_q[i] <= in_age;
        end
      end
    end
  end
endmodule

// File: rtl/swiq_checker.sv
module swiq_checker #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               full,
  input logic               flush_valid,
  input logic [DEPTH-1:0]   vld,
  input logic [DEPTH-1:0]   rdy1,
  input logic [DEPTH-1:0]   rdy2,
  input logic [DEPTH-1:0]   sel,
  input logic [ISSUE_W-1:0] iss_valid,
  input logic [ISSUE_W-1:0] iss_is_load,
  input logic [ISSUE_W-1:0] load_bc_vld
);
  localparam logic [ISSUE_W-1:0] ONE = {{(ISSUE_W-1){1'b0}}, 1'b1};

  p_slots_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid + ONE) & iss_valid) == '0);

  p_slot_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) == $countones(sel));

  p_full_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> ($countones(vld) == DEPTH));

  p_sources_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel & ~(rdy1 & rdy2)) == '0);

  p_issue_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |=> (($past(sel) & vld) == '0));

  p_load_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(iss_valid & iss_is_load)) |=> (|load_bc_vld));

  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && (sel == '0) && !flush_valid) |=> full);
endmodule

bind spec_wakeup_iq swiq_checker #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .flush_valid(flush_valid),
  .vld(vld_q), .rdy1(r1_q), .rdy2(r2_q), .sel(sel),
  .iss_valid(iss_valid), .iss_is_load(iss_is_load), .load_bc_vld(load_bc_vld)
);

// File: tb/sim_spec_wakeup_iq.sv
`timescale 1ns/100ps
module sim_spec_wakeup_iq;
  localparam int D = 8, W = 4, TW = 6, AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 0, in_src1_rdy = 0, in_src2_rdy = 0, in_is_load = 0, flush_valid = 0;
  logic [AW-1:0] in_age = '0, flush_age = '0;
  logic [TW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic          full;
  logic [W-1:0]  iss_valid, iss_is_load;
  logic [W*TW-1:0] iss_dst;

  spec_wakeup_iq #(.DEPTH(D), .ISSUE_W(W), .TAG_W(TW), .AGE_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_age(in_age), .in_dst(in_dst),
    .in_src1(in_src1), .in_src1_rdy(in_src1_rdy), .in_src2(in_src2), .in_src2_rdy(in_src2_rdy),
    .in_is_load(in_is_load), .flush_valid(flush_valid), .flush_age(flush_age),
    .full(full), .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_is_load(iss_is_load)
  );

  int errors = 0, checks = 0, next_age = 1;
  string req = "R1";
  bit done = 0;

  // behavioural model: a bag of pending instructions keyed by age
  bit mv[D], mr1[D], mr2[D], mld[D];
  int ms1[D], ms2[D], md[D], mage[D];
  bit plv[W];
  int plt[W];
  int ex_idx[W];
  int ex_n;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int occupancy();
    int n = 0;
    for (int i = 0; i < D; i++) if (mv[i]) n++;
    return n;
  endfunction

  task automatic predict();
    bit taken[D];
    ex_n = 0;
    for (int i = 0; i < D; i++) taken[i] = 0;
    repeat (W) begin
      int best = -1;
      for (int i = 0; i < D; i++) begin
        if (mv[i] && mr1[i] && mr2[i] && !taken[i] &&
            !(flush_valid && mage[i] > int'(flush_age)) &&
            (best < 0 || mage[i] < mage[best])) best = i;
      end
      if (best >= 0) begin
        taken[best] = 1;
        ex_idx[ex_n] = best;
        ex_n++;
      end
    end
  endtask

  task automatic compare();
    chk(req, "full", int'(full), int'(occupancy() == D));
    for (int s = 0; s < W; s++) begin
      if (s < ex_n) begin
        chk(req, $sformatf("slot%0d valid", s), int'(iss_valid[s]), 1);
        chk(req, $sformatf("slot%0d dst", s), int'(iss_dst[s*TW +: TW]), md[ex_idx[s]]);
        chk(req, $sformatf("slot%0d load", s), int'(iss_is_load[s]), int'(mld[ex_idx[s]]));
      end else begin
        chk(req, $sformatf("slot%0d valid", s), int'(iss_valid[s]), 0);
      end
    end
  endtask

  function automatic bit woke(int t);
    for (int s = 0; s < ex_n; s++) if (!mld[ex_idx[s]] && md[ex_idx[s]] == t) return 1;
    for (int s = 0; s < W; s++) if (plv[s] && plt[s] == t) return 1;
    return 0;
  endfunction

  task automatic update();
    int cnt = occupancy();
    bit gone[D];
    bit nlv[W];
    int nlt[W];
    for (int i = 0; i < D; i++) gone[i] = 0;
    for (int s = 0; s < W; s++) begin
      nlv[s] = (s < ex_n) && mld[ex_idx[s]];
      nlt[s] = (s < ex_n) ? md[ex_idx[s]] : 0;
      if (s < ex_n) gone[ex_idx[s]] = 1;
    end
    for (int i = 0; i < D; i++) begin
      if (mv[i]) begin
        if (gone[i] || (flush_valid && mage[i] > int'(flush_age))) mv[i] = 0;
        else begin
          if (woke(ms1[i])) mr1[i] = 1;
          if (woke(ms2[i])) mr2[i] = 1;
        end
      end
    end
    if (in_valid && cnt < D && !(flush_valid && int'(in_age) > int'(flush_age))) begin
      for (int i = 0; i < D; i++) begin
        if (!mv[i] && !gone[i]) begin
          mv[i] = 1; mage[i] = int'(in_age); md[i] = int'(in_dst); mld[i] = in_is_load;
          ms1[i] = int'(in_src1); ms2[i] = int'(in_src2);
          mr1[i] = in_src1_rdy || woke(int'(in_src1));
          mr2[i] = in_src2_rdy || woke(int'(in_src2));
          break;
        end
      end
    end
    for (int s = 0; s < W; s++) begin
      plv[s] = nlv[s];
      plt[s] = nlt[s];
    end
  endtask

  task automatic tick();
    #1;
    predict();
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
    in_valid = 0;
    flush_valid = 0;
  endtask

  task automatic put(int dst, int s1, bit r1, int s2, bit r2, bit ld);
    in_valid = 1; in_age = AW'(next_age); next_age++;
    in_dst = TW'(dst); in_src1 = TW'(s1); in_src1_rdy = r1;
    in_src2 = TW'(s2); in_src2_rdy = r2; in_is_load = ld;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic flush_all();
    flush_valid = 1; flush_age = '0;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < D; i++) mv[i] = 0;
    for (int s = 0; s < W; s++) plv[s] = 0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1", "reset iss_valid", int'(iss_valid), 0);
    chk("R1", "reset full", int'(full), 0);
    rst_n = 1;
    req = "R1"; idle(2);

    // R5 R6 R10: six consumers wait on a producer inserted last
    req = "R5";
    for (int k = 0; k < 6; k++) begin put(10 + k, 40, 0, 1, 1, 0); tick(); end
    req = "R6";
    put(40, 2, 1, 3, 1, 0); tick();
    req = "R5"; idle(2);
    req = "R10"; idle(2);

    // R4: ready-at-insert instruction issues the next cycle
    req = "R4";
    put(20, 1, 1, 2, 1, 0); tick(); idle(2);

    // R7 R8: load producer, plain dependent and one inserted on the broadcast cycle
    req = "R7";
    put(42, 1, 1, 2, 1, 1); tick();
    put(21, 42, 0, 3, 1, 0); tick();
    req = "R8";
    put(22, 3, 1, 42, 0, 0); tick();
    req = "R7"; idle(3);
    // R8 with an ALU producer issuing while its dependent is inserted
    req = "R8";
    put(43, 1, 1, 1, 1, 0); tick();
    put(23, 43, 0, 43, 0, 0); tick(); idle(2);

    // R3 R2 R9: fill with stuck entries, overfill, partial flush
    flush_all();
    req = "R3";
    base = next_age;
    for (int k = 0; k < D; k++) begin put(30 + k, 41, 0, 1, 1, 0); tick(); end
    idle(1);
    req = "R2";
    put(50, 1, 1, 1, 1, 0); tick(); idle(2);
    req = "R9";
    flush_valid = 1; flush_age = AW'(base + 3);
    put(51, 1, 1, 1, 1, 0); tick(); idle(2);
    req = "R6";
    put(41, 1, 1, 2, 1, 0); tick(); idle(3);
    // R9: a ready entry younger than the branch never issues
    req = "R9";
    flush_all();
    put(52, 1, 1, 1, 1, 0); tick();
    flush_valid = 1; flush_age = AW'(next_age - 2);
    tick(); idle(2);

    // mixed random traffic with periodic flushes
    req = "R5";
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) != 0)
        put($urandom_range(1, 20), $urandom_range(1, 20), $urandom_range(1) == 1,
            $urandom_range(1, 20), $urandom_range(1) == 1, $urandom_range(2) == 0);
      if (n % 37 == 36) begin
        flush_valid = 1;
        flush_age = AW'(next_age - 1 - $urandom_range(5));
      end
      tick();
    end
    req = "R9";
    flush_all(); idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule